// File: doc/BRIEF.md
# Dual Reloadable Down-Counter Timer

This peripheral holds two independent 32-bit timers that count down by one on every clock cycle while enabled. A single control word carries, for each timer, a run bit and an auto-reload bit. When a running timer sits at zero on a tick, it raises a one-cycle pulse on its own interrupt line. If auto-reload is set, the timer then copies its reload register into its counter; if not, it stops at zero and clears its own run bit.

Software reaches the block through a simple 32-bit register bus: a byte address, a write strobe, write data, and combinational read data. A one-shot delay is started by writing a count into a timer's counter register and then setting only its run bit. A periodic tick of N cycles is set up by writing N-1 into both the reload and counter registers and then setting the run and auto-reload bits together. A timer that is preloaded with all ones and has auto-reload set acts as a free-running timestamp when its counter value is read back bit-inverted.

Top module: `dtimer_top`

## Requirements
- R1: After reset, every register reads 0 and both interrupt outputs are low.
- R2: The control word sits at offset 0x00. Timer k uses bit 2k as its run bit and bit 2k+1 as its auto-reload bit. Bits 31..4 always read as 0, and writes to them have no effect.
- R3: Timer 0 has its reload register at 0x10 and its counter at 0x14. Timer 1 has its reload register at 0x18 and its counter at 0x1C. Each register reads back the last value written to it while its timer is stopped.
- R4: While its run bit is set, a timer's counter drops by one on every clock cycle until it reaches zero. A software write to the counter takes priority over the decrement.
- R5: With auto-reload clear, a counter started at N gives exactly one interrupt pulse. That pulse is high during the (N+1)th cycle after the edge that sets the run bit. At the same edge the timer clears its own run bit, and its counter stays at 0.
- R6: With auto-reload set and the reload value at P, the timer pulses its interrupt once every P+1 cycles and keeps running.
- R7: Clearing a run bit freezes that timer's counter at its current value.
- R8: Each timer drives only its own interrupt output. Activity on timer 0 never pulses timer 1's output.
- R9: If a timer is loaded with all ones and runs with auto-reload, the bit-inverted counter value grows by exactly one per clock cycle.
- R10: An interrupt pulse lasts one cycle whenever the reload period is longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one timer tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tmr_irq | output | 2 | Interrupt pulse per timer, bit k for timer k |

## Verification
The hardest case to reach is the edge on which a one-shot timer expires. On that same edge the hardware clears the run bit itself, the interrupt pulse rises, and the counter must stay at zero. The stimulus arms timer 0 with a small count and watches the interrupt line on every cycle that follows, so it can pin down the exact expiry cycle. It then reads the control word and the counter back, which shows that the self-clear happened and that the counter stayed frozen.

// File: rtl/dtimer_pkg.sv
// Shared constants and types for the dual down-counter timer.
// Assumes a byte-addressed bus with word-aligned registers.
package dtimer_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_CH    = 2;
    localparam int ADDR_W    = 5;
    localparam int CTRL_W    = 2 * NUM_CH;
    localparam int CH_STRIDE = 8;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CH   = 5'h10;

    // Per-timer control pair, in control-word bit order (run is the lower bit).
    typedef struct packed {
        logic autoreload;
        logic run;
    } ch_ctl_t;
endpackage

// File: rtl/dtimer_channel.sv
// One down-counting timer with a reload register.
// Decrements every cycle while run is high. At zero it pulses irq on the
// next cycle, then either reloads or asks the control register to stop it.
// Assumes that at most one write strobe is active per cycle.
module dtimer_channel #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         autoreload,
    input  logic         wr_reload,
    input  logic         wr_count,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] reload,
    output logic         irq,
    output logic         halt
);
    logic at_zero;
    assign at_zero = (count == '0);
    // Request to clear this timer's run bit (one-shot expiry).
    assign halt    = run && !autoreload && at_zero;

    // Reload register: written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload <= '0;
        else if (wr_reload) reload <= wdata;
    end

    // Counter: a software write wins; otherwise count down, or reload at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (wr_count) count <= wdata;
        else if (run) begin
            if (!at_zero)        count <= count - 1'b1;
            else if (autoreload) count <= reload;
        end
    end

    // Interrupt pulse: registered copy of "running and at zero".
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= run && at_zero;
    end

    // R7: a stopped timer keeps its counter unless software writes it.
    a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_count) |=> $stable(count));
    // R4: a running, non-zero counter drops by exactly one.
    a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count != '0 && !wr_count) |=> (count == $past(count) - 1'b1));
    // R6: at zero with auto-reload set, the counter takes the reload value.
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run && autoreload && count == '0 && !wr_count) |=> (count == $past(reload)));
    // R5: a pulse only follows a cycle where the timer ran at zero.
    a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(run && count == '0));
endmodule

// File: rtl/dtimer_ctrl.sv
// Shared control word: one run bit and one auto-reload bit per timer.
// A software write replaces the whole word. When there is no write in a
// cycle, a timer's halt request clears its run bit.
module dtimer_ctrl
    import dtimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] wdata,
    input  logic [NUM_CH-1:0] halt,
    output ch_ctl_t           ctl [NUM_CH]
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_bits
        // Per-timer control pair: software write, else self-clear on expiry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl[i] <= '0;
            end else if (wr_ctrl) begin
                ctl[i] <= wdata[2*i +: 2];
            end else if (halt[i]) begin
                ctl[i].run <= 1'b0;
            end
        end

        // R5: an expiring one-shot timer is stopped on the next cycle.
        a_r5_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
            (halt[i] && !wr_ctrl) |=> !ctl[i].run);
    end
endmodule

// File: rtl/dtimer_top.sv
// Dual reloadable down-counter timer with a simple register bus.
// Decodes exact word addresses and returns 0 for unmapped reads.
// Assumes one tick per clock cycle, with no prescaler.
module dtimer_top
    import dtimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] tmr_irq
);
    ch_ctl_t           ctl [NUM_CH];
    logic [NUM_CH-1:0] halt;
    logic [DATA_W-1:0] cnt_q [NUM_CH];
    logic [DATA_W-1:0] rld_q [NUM_CH];
    logic              wr_ctrl;

    assign wr_ctrl = bus_we && (bus_addr == OFS_CTRL);

    dtimer_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wdata   (bus_wdata[CTRL_W-1:0]),
        .halt    (halt),
        .ctl     (ctl)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_RLD = OFS_CH + ADDR_W'(i * CH_STRIDE);
        localparam logic [ADDR_W-1:0] A_CNT = A_RLD + ADDR_W'(4);
        logic wr_rld, wr_cnt;
        assign wr_rld = bus_we && (bus_addr == A_RLD);
        assign wr_cnt = bus_we && (bus_addr == A_CNT);

        dtimer_channel #(.W(DATA_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (ctl[i].run),
            .autoreload (ctl[i].autoreload),
            .wr_reload  (wr_rld),
            .wr_count   (wr_cnt),
            .wdata      (bus_wdata),
            .count      (cnt_q[i]),
            .reload     (rld_q[i]),
            .irq        (tmr_irq[i]),
            .halt       (halt[i])
        );
    end

    // Read mux: control word zero-extended, then the per-timer registers.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CTRL) begin
            for (int i = 0; i < NUM_CH; i++) bus_rdata[2*i +: 2] = ctl[i];
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == OFS_CH + ADDR_W'(i * CH_STRIDE))     bus_rdata = rld_q[i];
            if (bus_addr == OFS_CH + ADDR_W'(i * CH_STRIDE + 4)) bus_rdata = cnt_q[i];
        end
    end

    // R2: the upper control bits always read as zero.
    a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CTRL) |-> (bus_rdata[DATA_W-1:CTRL_W] == '0));
endmodule

// File: tb/sim_dtimer_top.sv
// Directed bench for dtimer_top: one task per scenario.
module sim_dtimer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  tmr_irq;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dtimer_top u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        foreach (v[i]) ;
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), v);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 irq at reset", {30'h0, tmr_irq}, 32'h0);
    endtask

    task automatic t_ctrl_upper;
        logic [31:0] v;
        wr(5'h00, 32'hFFFF_FFF0);
        rd(5'h00, v);
        check("R2 upper control bits ignored", v, 32'h0);
    endtask

    task automatic t_readback;
        logic [31:0] v;
        wr(5'h18, 32'hA5A5_1234);
        wr(5'h1C, 32'h0BAD_F00D);
        wr(5'h10, 32'h0000_0042);
        rd(5'h18, v); check("R3 timer1 reload readback", v, 32'hA5A5_1234);
        rd(5'h1C, v); check("R3 timer1 counter readback", v, 32'h0BAD_F00D);
        rd(5'h10, v); check("R3 timer0 reload readback", v, 32'h0000_0042);
    endtask

    // One-shot on timer 0 with count n: a single pulse at cycle n+1.
    task automatic t_oneshot(input int n);
        logic [31:0] v;
        int first = -1;
        int pulses = 0;
        int other = 0;
        wr(5'h14, 32'(n));
        wr(5'h00, 32'h1);
        for (int k = 1; k <= n + 12; k++) begin
            @(negedge clk);
            if (tmr_irq[0]) begin
                pulses++;
                if (first < 0) first = k;
            end
            if (tmr_irq[1]) other++;
        end
        check("R5 one-shot pulse cycle", 32'(first), 32'(n + 1));
        check("R5 one-shot pulse count", 32'(pulses), 32'd1);
        check("R8 timer1 irq stays low", 32'(other), 32'd0);
        rd(5'h00, v); check("R5 run bit self-cleared", v, 32'h0);
        rd(5'h14, v); check("R5 counter stays at zero", v, 32'h0);
    endtask

    // Periodic on timer 0 with reload p: a pulse every p+1 cycles.
    task automatic t_periodic(input int p);
        int last = -1;
        int pulses = 0;
        int bad_gap = 0;
        int wide = 0;
        logic prev = 1'b0;
        wr(5'h10, 32'(p));
        wr(5'h14, 32'(p));
        wr(5'h00, 32'h3);
        for (int k = 1; k <= 10 * (p + 1); k++) begin
            @(negedge clk);
            if (tmr_irq[0]) begin
                pulses++;
                if (last >= 0 && k - last != p + 1) bad_gap++;
                if (prev) wide++;
                last = k;
            end
            prev = tmr_irq[0];
        end
        wr(5'h00, 32'h0);
        check("R6 periodic gap errors", 32'(bad_gap), 32'd0);
        check("R6 periodic keeps firing", 32'(pulses >= 8), 32'd1);
        check("R10 pulse lasts one cycle", 32'(wide), 32'd0);
    endtask

    task automatic t_freeze;
        logic [31:0] v1, v2;
        wr(5'h1C, 32'd1000);
        wr(5'h00, 32'h4);
        repeat (10) @(negedge clk);
        wr(5'h00, 32'h0);
        rd(5'h1C, v1);
        check("R4 timer1 counted down", 32'(v1 < 32'd1000 && v1 > 32'd980), 32'd1);
        repeat (20) @(negedge clk);
        rd(5'h1C, v2);
        check("R7 counter frozen when stopped", v2, v1);
    endtask

    task automatic t_freerun;
        logic [31:0] a, b;
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h00, 32'h3);
        rd(5'h14, a);
        repeat (7) @(negedge clk);
        rd(5'h14, b);
        check("R9 inverted counter rises", (~b) - (~a), 32'd7);
        wr(5'h00, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_upper();
        t_readback();
        t_oneshot(5);
        t_oneshot(0);
        t_periodic(3);
        t_periodic(1);
        t_freeze();
        t_freerun();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule